// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Configuration Controls

This block is the test access port of a programmable device. A standard 16-state controller advances on rising TCK edges. It steers a 10-bit instruction register and a set of data registers between the serial input `tdi` and the serial output `tdo`. Besides the usual scan instructions, some opcodes leave control lines behind them: a tri-state request for all pins, a request to hold the pins from the boundary-scan register, a one-cycle reconfiguration request, a sticky selector for the configuration clock, and a sticky flag that parks the active configuration controller. One further opcode places a boot-address register in the scan path.

The physical I/O cells and the flash controller lie outside the block and are seen only as ports. The captured pin values arrive on `pin_in`. The boundary-scan update stage leaves on `pin_drive`, and the boot address leaves on `boot_addr`. An external board tester drives TMS and TDI, reads TDO, and uses `trst_n` as an optional asynchronous reset.

Top module: `cfg_tap_top`

## Requirements
- R1: While `trst_n` is low, the controller sits in Test-Logic-Reset, IDCODE is the active instruction, `clk_sel_user`, `ctrl_disengaged` and `reconfig_pulse` are low, and `tdo_oe` is low.
- R2: The controller follows the standard 16-state graph on rising TCK. Five TCK cycles with TMS high reach Test-Logic-Reset from any state. Each cycle spent there restores IDCODE and clears both sticky latches.
- R3: Capture-IR loads the instruction shifter with binary 00_0000_0001. Shift-IR moves it towards TDO least significant bit first, with TDI entering at the most significant end.
- R4: TDO and `tdo_oe` change only on falling TCK. `tdo_oe` is high exactly while the controller is in Shift-DR or Shift-IR, and TDO is low whenever `tdo_oe` is low.
- R5: The active instruction changes only on the rising edge that leaves Update-IR. BYPASS (all ones) and every opcode not listed in R6 to R13 select a 1-bit register that captures 0.
- R6: IDCODE (0x006) and USERCODE (0x007) each select a 32-bit register. It captures the parameter value and shifts it out least significant bit first.
- R7: SAMPLE/PRELOAD (0x005) and EXTEST (0x00F) select the boundary-scan register. It captures `pin_in` in Capture-DR and copies into `pin_drive` in Update-DR. `pin_test_mode` is high while EXTEST or CLAMP is active.
- R8: HIGHZ (0x00B) raises `pin_hiz` and CLAMP (0x00A) raises `pin_test_mode`. Both select the 1-bit bypass register, and neither changes `pin_drive`.
- R9: Opcode 0x270 selects a 22-bit boot-address register. It captures the current `boot_addr`, and Update-DR loads the shifted value into `boot_addr`.
- R10: Opcode 0x1EE sets `clk_sel_user` and opcode 0x2EE clears it. The value persists across all other instructions.
- R11: Opcode 0x2D0 sets `ctrl_disengaged` and opcode 0x2B0 clears it. The value persists across all other instructions.
- R12: Opcode 0x001 raises `reconfig_pulse` for exactly one TCK cycle, starting at the edge that leaves Update-IR.
- R13: While opcode 0x00D is active, `io_cfg_en` follows `nstatus` and stays low when `nstatus` is low. The opcode selects the bypass register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| nstatus | input | 1 | Configuration status pin, high when ready |
| pin_in | input | BSR_LEN | Pin values captured into the boundary-scan register |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| pin_drive | output | BSR_LEN | Boundary-scan update stage |
| pin_test_mode | output | 1 | Pins driven from `pin_drive` (EXTEST, CLAMP) |
| pin_hiz | output | 1 | All pins tri-stated (HIGHZ) |
| reconfig_pulse | output | 1 | One-cycle reconfiguration request |
| clk_sel_user | output | 1 | Configuration clock taken from the user clock pin |
| ctrl_disengaged | output | 1 | Active configuration controller parked |
| io_cfg_en | output | 1 | I/O configuration access granted |
| boot_addr | output | BOOT_W | Boot address for the flash controller |

## Verification
A behavioural model of the controller and its registers runs next to the design and is compared on every TCK cycle. Scans of each 32-bit register against known constants show whether the register is selected correctly and the bit order is right. Unlisted opcodes and the all-ones opcode must yield a single 0 followed by the shifted TDI bits, which separates a working bypass from a wrongly selected wide register. A boot-address scan with a pause in the middle, sticky-latch opcodes followed by unrelated instructions, a reset by TMS from the middle of a shift and an asynchronous reset together tell persistent state apart from state that is lost or cleared when it should not be.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;

  localparam int IR_W = 10;

  // Standard boundary-scan opcodes
  localparam logic [IR_W-1:0] OP_BYPASS   = 10'h3FF;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST   = 10'h00F;
  localparam logic [IR_W-1:0] OP_USERCODE = 10'h007;
  localparam logic [IR_W-1:0] OP_IDCODE   = 10'h006;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 10'h00B;
  localparam logic [IR_W-1:0] OP_CLAMP    = 10'h00A;
  // Configuration opcodes
  localparam logic [IR_W-1:0] OP_RECONFIG  = 10'h001;
  localparam logic [IR_W-1:0] OP_IOCFG     = 10'h00D;
  localparam logic [IR_W-1:0] OP_CLK_USER  = 10'h1EE;
  localparam logic [IR_W-1:0] OP_CLK_OSC   = 10'h2EE;
  localparam logic [IR_W-1:0] OP_CTRL_OFF  = 10'h2D0;
  localparam logic [IR_W-1:0] OP_CTRL_ON   = 10'h2B0;
  localparam logic [IR_W-1:0] OP_BOOT_ADDR = 10'h270;

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    DRS_BYPASS, DRS_IDCODE, DRS_USER, DRS_BSR, DRS_BOOT
  } dr_sel_e;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    tap_state_e n;
    case (s)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e dr_decode(logic [IR_W-1:0] op);
    dr_sel_e d;
    case (op)
      OP_IDCODE:             d = DRS_IDCODE;
      OP_USERCODE:           d = DRS_USER;
      OP_SAMPLE, OP_EXTEST:  d = DRS_BSR;
      OP_BOOT_ADDR:          d = DRS_BOOT;
      default:               d = DRS_BYPASS;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cfg_tap_fsm.sv
module cfg_tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q;
  logic       in_tlr_ev;

  assign state     = state_q;
  assign in_tlr_ev = (state_q == ST_TLR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_TLR;
    else         state_q <= tap_next(state_q, tms);
  end

  // R2: TMS high in Test-Logic-Reset keeps the controller there
  p_tlr_hold_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (in_tlr_ev && tms) |=> (state_q == ST_TLR));

  // R2: leaving an update state always lands in Run-Test/Idle or Select-DR
  p_upd_exit_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_UPD_IR || state_q == ST_UPD_DR) |=>
      (state_q == ST_RTI || state_q == ST_SEL_DR));

endmodule

// File: rtl/cfg_tap_ir.sv
module cfg_tap_ir
  import cfg_tap_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  tap_state_e       state,
  input  logic             tdi,
  input  logic             nstatus,
  output logic             ir_lsb,
  output dr_sel_e          dr_sel,
  output logic             pin_hiz,
  output logic             pin_test_mode,
  output logic             clk_sel_user,
  output logic             ctrl_disengaged,
  output logic             reconfig_pulse,
  output logic             io_cfg_en
);

  logic [IR_W-1:0] ir_sr, instr;
  logic            clk_q, dis_q, pulse_q;
  logic            cap_ev, sh_ev, upd_ev, rst_ev;

  assign cap_ev = (state == ST_CAP_IR);
  assign sh_ev  = (state == ST_SH_IR);
  assign upd_ev = (state == ST_UPD_IR);
  assign rst_ev = (state == ST_TLR);

  // Instruction shifter
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ir_sr <= IR_CAPTURE;
    else if (cap_ev) ir_sr <= IR_CAPTURE;
    else if (sh_ev)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // Active instruction
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     instr <= OP_IDCODE;
    else if (rst_ev) instr <= OP_IDCODE;
    else if (upd_ev) instr <= ir_sr;
  end

  // Sticky configuration latches
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      clk_q <= 1'b0;
      dis_q <= 1'b0;
    end else if (rst_ev) begin
      clk_q <= 1'b0;
      dis_q <= 1'b0;
    end else if (upd_ev) begin
      if (ir_sr == OP_CLK_USER)      clk_q <= 1'b1;
      else if (ir_sr == OP_CLK_OSC)  clk_q <= 1'b0;
      if (ir_sr == OP_CTRL_OFF)      dis_q <= 1'b1;
      else if (ir_sr == OP_CTRL_ON)  dis_q <= 1'b0;
    end
  end

  // One-cycle reconfiguration request
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) pulse_q <= 1'b0;
    else         pulse_q <= upd_ev && (ir_sr == OP_RECONFIG);
  end

  assign ir_lsb          = ir_sr[0];
  assign dr_sel          = dr_decode(instr);
  assign pin_hiz         = (instr == OP_HIGHZ);
  assign pin_test_mode   = (instr == OP_EXTEST) || (instr == OP_CLAMP);
  assign io_cfg_en       = (instr == OP_IOCFG) && nstatus;
  assign clk_sel_user    = clk_q;
  assign ctrl_disengaged = dis_q;
  assign reconfig_pulse  = pulse_q;

  // R3: capture loads the fixed 01 pattern
  p_capir_r3: assert property (@(posedge tck) disable iff (!trst_n)
    cap_ev |=> (ir_sr == IR_CAPTURE));

  // R5: instruction moves only on update or reset
  p_instr_stable_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_ev && !rst_ev) |=> $stable(instr));

  // R10: clock select holds outside update and reset
  p_clksel_hold_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_ev && !rst_ev) |=> $stable(clk_sel_user));

  // R11: controller park flag holds outside update and reset
  p_park_hold_r11: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_ev && !rst_ev) |=> $stable(ctrl_disengaged));

  // R12: reconfiguration request never lasts two cycles
  p_pulse_one_r12: assert property (@(posedge tck) disable iff (!trst_n)
    reconfig_pulse |=> !reconfig_pulse);

  // R13: grant never present without nstatus
  p_iocfg_gate_r13: assert property (@(posedge tck) disable iff (!trst_n)
    io_cfg_en |-> nstatus);

  // R8: tri-state and clamp never together
  p_hiz_excl_r8: assert property (@(posedge tck) disable iff (!trst_n)
    pin_hiz |-> !pin_test_mode);

endmodule

// File: rtl/cfg_tap_dr.sv
module cfg_tap_dr
  import cfg_tap_pkg::*;
#(
  parameter int          BSR_LEN   = 8,
  parameter int          BOOT_W    = 22,
  parameter logic [31:0] ID_CODE   = 32'h1A2B_30DD,
  parameter logic [31:0] USER_CODE = 32'h0000_0000,
  parameter logic [BOOT_W-1:0] BOOT_RST = '0
)(
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  dr_sel_e            dr_sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] pin_drive,
  output logic [BOOT_W-1:0]  boot_addr
);

  localparam int CODE_W = 32;

  logic                byp_sr;
  logic [CODE_W-1:0]   id_sr, user_sr;
  logic [BSR_LEN-1:0]  bsr_sr, bsr_upd;
  logic [BOOT_W-1:0]   boot_sr, boot_q;
  logic                cap_ev, sh_ev, upd_ev;
  logic                bsr_cap, bsr_sh, bsr_load;

  assign cap_ev   = (state == ST_CAP_DR);
  assign sh_ev    = (state == ST_SH_DR);
  assign upd_ev   = (state == ST_UPD_DR);
  assign bsr_cap  = cap_ev && (dr_sel == DRS_BSR);
  assign bsr_sh   = sh_ev  && (dr_sel == DRS_BSR);
  assign bsr_load = upd_ev && (dr_sel == DRS_BSR);

  // Bypass, code and boot shifters
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_sr  <= 1'b0;
      id_sr   <= ID_CODE;
      user_sr <= USER_CODE;
      boot_sr <= BOOT_RST;
    end else if (cap_ev) begin
      case (dr_sel)
        DRS_IDCODE: id_sr   <= ID_CODE;
        DRS_USER:   user_sr <= USER_CODE;
        DRS_BOOT:   boot_sr <= boot_q;
        DRS_BYPASS: byp_sr  <= 1'b0;
        default:    ;
      endcase
    end else if (sh_ev) begin
      case (dr_sel)
        DRS_IDCODE: id_sr   <= {tdi, id_sr[CODE_W-1:1]};
        DRS_USER:   user_sr <= {tdi, user_sr[CODE_W-1:1]};
        DRS_BOOT:   boot_sr <= {tdi, boot_sr[BOOT_W-1:1]};
        DRS_BYPASS: byp_sr  <= tdi;
        default:    ;
      endcase
    end
  end

  // Boot address update stage
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          boot_q <= BOOT_RST;
    else if (upd_ev && dr_sel == DRS_BOOT) boot_q <= boot_sr;
  end

  // Boundary-scan cells: capture, shift, update per pin
  for (genvar g = 0; g < BSR_LEN; g++) begin : g_bsr_cell
    logic shin, cell_q, upd_q;
    if (g == BSR_LEN - 1) begin : g_head
      assign shin = tdi;
    end else begin : g_body
      assign shin = bsr_sr[g+1];
    end
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      cell_q <= 1'b0;
      else if (bsr_cap) cell_q <= pin_in[g];
      else if (bsr_sh)  cell_q <= shin;
    end
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)       upd_q <= 1'b0;
      else if (bsr_load) upd_q <= cell_q;
    end
    assign bsr_sr[g]  = cell_q;
    assign bsr_upd[g] = upd_q;
  end

  always_comb begin
    case (dr_sel)
      DRS_IDCODE: dr_lsb = id_sr[0];
      DRS_USER:   dr_lsb = user_sr[0];
      DRS_BSR:    dr_lsb = bsr_sr[0];
      DRS_BOOT:   dr_lsb = boot_sr[0];
      default:    dr_lsb = byp_sr;
    endcase
  end

  assign pin_drive = bsr_upd;
  assign boot_addr = boot_q;

  // R5: the bypass cell captures zero
  p_byp_cap_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_ev && dr_sel == DRS_BYPASS) |=> !byp_sr);

  // R7: pin update stage moves only in Update-DR with the scan chain selected
  p_bsr_hold_r7: assert property (@(posedge tck) disable iff (!trst_n)
    !bsr_load |=> $stable(pin_drive));

  // R9: boot address moves only in Update-DR with the boot register selected
  p_boot_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !(upd_ev && dr_sel == DRS_BOOT) |=> $stable(boot_addr));

endmodule

// File: rtl/cfg_tap_top.sv
module cfg_tap_top
  import cfg_tap_pkg::*;
#(
  parameter int          BSR_LEN   = 8,
  parameter int          BOOT_W    = 22,
  parameter logic [31:0] ID_CODE   = 32'h1A2B_30DD,
  parameter logic [31:0] USER_CODE = 32'h0000_0000,
  parameter logic [BOOT_W-1:0] BOOT_RST = '0
)(
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic               nstatus,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [BSR_LEN-1:0] pin_drive,
  output logic               pin_test_mode,
  output logic               pin_hiz,
  output logic               reconfig_pulse,
  output logic               clk_sel_user,
  output logic               ctrl_disengaged,
  output logic               io_cfg_en,
  output logic [BOOT_W-1:0]  boot_addr
);

  tap_state_e state;
  dr_sel_e    dr_sel;
  logic       ir_lsb, dr_lsb;
  logic       sh_ir_ev, sh_dr_ev;
  logic       tdo_q, oe_q;

  cfg_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  cfg_tap_ir u_ir (
    .tck             (tck),
    .trst_n          (trst_n),
    .state           (state),
    .tdi             (tdi),
    .nstatus         (nstatus),
    .ir_lsb          (ir_lsb),
    .dr_sel          (dr_sel),
    .pin_hiz         (pin_hiz),
    .pin_test_mode   (pin_test_mode),
    .clk_sel_user    (clk_sel_user),
    .ctrl_disengaged (ctrl_disengaged),
    .reconfig_pulse  (reconfig_pulse),
    .io_cfg_en       (io_cfg_en)
  );

  cfg_tap_dr #(
    .BSR_LEN   (BSR_LEN),
    .BOOT_W    (BOOT_W),
    .ID_CODE   (ID_CODE),
    .USER_CODE (USER_CODE),
    .BOOT_RST  (BOOT_RST)
  ) u_dr (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (state),
    .dr_sel    (dr_sel),
    .tdi       (tdi),
    .pin_in    (pin_in),
    .dr_lsb    (dr_lsb),
    .pin_drive (pin_drive),
    .boot_addr (boot_addr)
  );

  assign sh_ir_ev = (state == ST_SH_IR);
  assign sh_dr_ev = (state == ST_SH_DR);

  // Output stage on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= sh_ir_ev || sh_dr_ev;
      tdo_q <= sh_ir_ev ? ir_lsb : (sh_dr_ev ? dr_lsb : 1'b0);
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // R4: enable at a rising edge matches the shift state held since the last one
  p_oe_shift_r4: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (sh_ir_ev || sh_dr_ev));

  // R4: TDO idles low while not enabled
  p_tdo_idle_r4: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);

endmodule

// File: tb/cfg_tap_tb.sv
module cfg_tap_top_tb_top;

  localparam int          TCK_PERIOD = 20;
  localparam int          NPIN   = 8;
  localparam int          NBOOT  = 22;
  localparam logic [31:0] K_ID   = 32'h5EC3_A0F7;
  localparam logic [31:0] K_USER = 32'h9D41_2C6B;
  localparam logic [NBOOT-1:0] K_BOOT0 = 22'h012345;

  // bench state numbering
  localparam int A_RST = 0,  A_IDLE = 1;
  localparam int A_DSEL = 2, A_DCAP = 3, A_DSH = 4, A_DX1 = 5, A_DPA = 6, A_DX2 = 7, A_DUP = 8;
  localparam int A_ISEL = 9, A_ICAP = 10, A_ISH = 11, A_IX1 = 12, A_IPA = 13, A_IX2 = 14, A_IUP = 15;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, nstatus = 1'b0;
  logic [NPIN-1:0]  pin_in = '0;
  logic             tdo, tdo_oe, pin_test_mode, pin_hiz, reconfig_pulse;
  logic             clk_sel_user, ctrl_disengaged, io_cfg_en;
  logic [NPIN-1:0]  pin_drive;
  logic [NBOOT-1:0] boot_addr;

  int n_vec = 0, n_bad = 0, cyc = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  cfg_tap_top #(
    .BSR_LEN(NPIN), .BOOT_W(NBOOT), .ID_CODE(K_ID), .USER_CODE(K_USER), .BOOT_RST(K_BOOT0)
  ) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .nstatus(nstatus), .pin_in(pin_in),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_drive(pin_drive), .pin_test_mode(pin_test_mode),
    .pin_hiz(pin_hiz), .reconfig_pulse(reconfig_pulse), .clk_sel_user(clk_sel_user),
    .ctrl_disengaged(ctrl_disengaged), .io_cfg_en(io_cfg_en), .boot_addr(boot_addr)
  );

  // ---------------- reference model ----------------
  int               m_st;
  logic [9:0]       m_ir, m_op;
  logic             m_byp, m_clk, m_park, m_pulse;
  logic [31:0]      m_id, m_user;
  logic [NPIN-1:0]  m_bsr, m_pins;
  logic [NBOOT-1:0] m_bsh, m_boot;

  function automatic int walk(int s, logic m);
    int t [16][2];
    t[A_RST] = '{A_IDLE, A_RST};  t[A_IDLE] = '{A_IDLE, A_DSEL};
    t[A_DSEL] = '{A_DCAP, A_ISEL}; t[A_DCAP] = '{A_DSH, A_DX1};
    t[A_DSH] = '{A_DSH, A_DX1};   t[A_DX1] = '{A_DPA, A_DUP};
    t[A_DPA] = '{A_DPA, A_DX2};   t[A_DX2] = '{A_DSH, A_DUP};
    t[A_DUP] = '{A_IDLE, A_DSEL}; t[A_ISEL] = '{A_ICAP, A_RST};
    t[A_ICAP] = '{A_ISH, A_IX1};  t[A_ISH] = '{A_ISH, A_IX1};
    t[A_IX1] = '{A_IPA, A_IUP};   t[A_IPA] = '{A_IPA, A_IX2};
    t[A_IX2] = '{A_ISH, A_IUP};   t[A_IUP] = '{A_IDLE, A_DSEL};
    return t[s][m ? 1 : 0];
  endfunction

  // 0 bypass, 1 id, 2 user, 3 boundary, 4 boot
  function automatic int which(logic [9:0] op);
    if (op == 10'h006) return 1;
    if (op == 10'h007) return 2;
    if (op == 10'h005 || op == 10'h00F) return 3;
    if (op == 10'h270) return 4;
    return 0;
  endfunction

  task automatic model_reset();
    m_st = A_RST; m_op = 10'h006; m_ir = 10'h001; m_byp = 0;
    m_clk = 0; m_park = 0; m_pulse = 0;
    m_id = K_ID; m_user = K_USER; m_bsr = '0; m_pins = '0;
    m_bsh = K_BOOT0; m_boot = K_BOOT0;
  endtask

  task automatic model_edge(logic mi, logic di);
    int nxt, w;
    nxt = walk(m_st, mi);
    w = which(m_op);
    m_pulse = (m_st == A_IUP) && (m_ir == 10'h001);
    case (m_st)
      A_RST: begin m_op = 10'h006; m_clk = 0; m_park = 0; end
      A_ICAP: m_ir = 10'h001;
      A_ISH:  m_ir = {di, m_ir[9:1]};
      A_IUP: begin
        m_op = m_ir;
        if (m_ir == 10'h1EE) m_clk = 1;
        if (m_ir == 10'h2EE) m_clk = 0;
        if (m_ir == 10'h2D0) m_park = 1;
        if (m_ir == 10'h2B0) m_park = 0;
      end
      A_DCAP: case (w)
        0: m_byp = 0; 1: m_id = K_ID; 2: m_user = K_USER;
        3: m_bsr = pin_in; default: m_bsh = m_boot;
      endcase
      A_DSH: case (w)
        0: m_byp = di; 1: m_id = {di, m_id[31:1]}; 2: m_user = {di, m_user[31:1]};
        3: m_bsr = {di, m_bsr[NPIN-1:1]}; default: m_bsh = {di, m_bsh[NBOOT-1:1]};
      endcase
      A_DUP: begin
        if (w == 3) m_pins = m_bsr;
        if (w == 4) m_boot = m_bsh;
      end
      default: ;
    endcase
    m_st = nxt;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    logic et; int w;
    w = which(m_op);
    et = 0;
    if (m_st == A_ISH) et = m_ir[0];
    if (m_st == A_DSH)
      case (w)
        0: et = m_byp; 1: et = m_id[0]; 2: et = m_user[0];
        3: et = m_bsr[0]; default: et = m_bsh[0];
      endcase
    chk("R4 tdo_oe", 32'(tdo_oe), 32'(m_st == A_ISH || m_st == A_DSH));
    if (m_st == A_ISH)       chk("R3 tdo in Shift-IR", 32'(tdo), 32'(et));
    else if (m_st != A_DSH)  chk("R4 tdo idle", 32'(tdo), 32'(et));
    else case (w)
      0: chk("R5 tdo bypass", 32'(tdo), 32'(et));
      1, 2: chk("R6 tdo code", 32'(tdo), 32'(et));
      3: chk("R7 tdo boundary", 32'(tdo), 32'(et));
      default: chk("R9 tdo boot", 32'(tdo), 32'(et));
    endcase
    chk("R7 pin_drive", 32'(pin_drive), 32'(m_pins));
    chk("R7 pin_test_mode", 32'(pin_test_mode), 32'(m_op == 10'h00F || m_op == 10'h00A));
    chk("R8 pin_hiz", 32'(pin_hiz), 32'(m_op == 10'h00B));
    chk("R9 boot_addr", 32'(boot_addr), 32'(m_boot));
    chk("R10 clk_sel_user", 32'(clk_sel_user), 32'(m_clk));
    chk("R11 ctrl_disengaged", 32'(ctrl_disengaged), 32'(m_park));
    chk("R12 reconfig_pulse", 32'(reconfig_pulse), 32'(m_pulse));
    chk("R13 io_cfg_en", 32'(io_cfg_en), 32'(m_op == 10'h00D && nstatus));
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic step(logic mi, logic di);
    tms = mi; tdi = di;
    @(posedge tck);
    model_edge(mi, di);
    @(negedge tck); #1;
    compare_all();
  endtask

  task automatic load_ir(logic [9:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) step(i == 9, op[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(logic [31:0] d, int n);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, d[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic async_reset();
    @(negedge tck); #2;
    trst_n = 0; tms = 1; #2;
    model_reset();
    compare_all();        // R1 state during reset
    @(negedge tck); #3;
    trst_n = 1;
  endtask

  // ---------------- watchdog ----------------
  always @(posedge tck) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    model_reset();
    pin_in = 8'hA5;
    repeat (2) @(negedge tck);
    #1 compare_all();     // R1 reset state
    trst_n = 1;
    step(0, 0);           // to Run-Test/Idle
    scan_dr(32'h0, 32);   // R1/R6 default IDCODE
    load_ir(10'h007); scan_dr(32'hFFFF_0000, 32);   // R6 user code
    load_ir(10'h3FF); scan_dr(32'h0000_000D, 4);    // R5 bypass
    load_ir(10'h155); scan_dr(32'h0000_0006, 3);    // R5 unlisted opcode
    load_ir(10'h005); scan_dr(32'h0000_003C, 8);    // R7 sample/preload
    pin_in = 8'h5A;
    load_ir(10'h00F); scan_dr(32'h0000_00C3, 8);    // R7 extest
    load_ir(10'h00A); scan_dr(32'h0000_0001, 2);    // R8 clamp
    load_ir(10'h00B); scan_dr(32'h0000_0002, 2);    // R8 highz
    load_ir(10'h270); scan_dr(32'h002A_BCD1, 22);   // R9 boot load
    // R9 readback with a pause in the middle
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) step(i == 9, 1'b1);
    step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int i = 0; i < 12; i++) step(i == 11, 1'b0);
    step(1, 0); step(0, 0);
    load_ir(10'h1EE); load_ir(10'h006); scan_dr(32'h0, 8);   // R10 set, sticky
    load_ir(10'h2EE);                                        // R10 clear
    load_ir(10'h2D0); load_ir(10'h007);                      // R11 set, sticky
    load_ir(10'h2B0);                                        // R11 clear
    load_ir(10'h001); step(0, 0); step(0, 0);                // R12 pulse
    nstatus = 0; load_ir(10'h00D); step(0, 0);               // R13 gated off
    nstatus = 1; step(0, 0); step(0, 0);                     // R13 granted
    scan_dr(32'h0000_0001, 3);                               // R13 bypass
    nstatus = 0; step(0, 0);
    load_ir(10'h1EE); load_ir(10'h2D0);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);          // in Shift-DR
    for (int i = 0; i < 6; i++) step(1, 0);                  // R2 TMS reset
    step(0, 0);
    load_ir(10'h1EE); load_ir(10'h270);
    async_reset();                                           // R1 mid-run
    step(0, 0); scan_dr(32'h0, 32);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule